// File: doc/BRIEF.md
# Periodic Strobe Trigger Sequencer

This block turns one-cycle trigger pulses into framing windows. A trigger that arrives while the window is closed opens it on the next clock. The window then stays open for a programmed number of cycles. A trigger that arrives while the window is open extends it: the count restarts, and the frame is marked as extended. The frame formatter reads that mark.

An optional internal sequencer repeats windows without further external triggers. While the enable bit is high, one external trigger arms the sequencer. From then on, each closed window is followed by a programmed gap, and then an internally made trigger opens the next window. That internal trigger takes the same path as an external one. The period is therefore the duration plus the gap. Another external trigger re-times the pattern. Clearing the enable bit stops it and disarms it.

Top module: `strobe_sequencer`

## Requirements
- R1: After reset, `strobe_o`, `strobe_start_o` and `strobe_ext_o` are all low.
- R2: A trigger sampled while `strobe_o` is low raises `strobe_o` on the next cycle. `strobe_o` then stays high for exactly `dur_cfg` cycles.
- R3: A `dur_cfg` of zero gives a window of one cycle.
- R4: `strobe_start_o` is high for exactly one cycle: the first cycle of each window. It is low at all other times.
- R5: An external trigger sampled while `strobe_o` is high keeps the window open. The window closes `dur_cfg` cycles after that trigger's edge, counting only high cycles.
- R6: `strobe_ext_o` rises on the cycle after an extending trigger. It holds after the window closes and reads 0 from the first cycle of the next window.
- R7: Raising `seq_en` with no external trigger produces no window.
- R8: Once armed, a window that closes is followed by `gap_cfg` low cycles and then a new window. The start-to-start period is `dur_cfg + gap_cfg`.
- R9: A `gap_cfg` of zero gives one low cycle between windows.
- R10: Clearing `seq_en` stops new internal windows. A window that is already open still runs to its end.
- R11: An external trigger during the gap opens a window on the next cycle. The following period is counted from that window.
- R12: An external trigger sampled with `seq_en` high arms the sequencer, and `seq_en` low disarms it. After re-enabling, no window appears until a new external trigger arrives.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| trig_i | input | 1 | External trigger, one-cycle pulse |
| seq_en | input | 1 | Internal sequencer enable |
| dur_cfg | input | CNT_W | Window length in cycles |
| gap_cfg | input | CNT_W | Low time between internal windows in cycles |
| strobe_o | output | 1 | Framing window level |
| strobe_start_o | output | 1 | One-cycle pulse on the first cycle of a window |
| strobe_ext_o | output | 1 | Current or last window was extended |

## Verification
The hardest case to reach from the ports is an external trigger that lands inside the gap of a running internal sequence. Hitting it needs an armed sequencer and a trigger placed on an exact low cycle. Directed steps first measure the running period, then count cycles from an observed start pulse to find the gap, and fire there. Random stimulus keeps varying the trigger density, the enable and short duration and gap values. This drives extension, re-timing and disarming into many overlaps, and a cycle model in the bench follows every cycle.

// File: rtl/strobe_sequencer.sv
module strobe_sequencer #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             trig_i,
  input  logic             seq_en,
  input  logic [CNT_W-1:0] dur_cfg,
  input  logic [CNT_W-1:0] gap_cfg,
  output logic             strobe_o,
  output logic             strobe_start_o,
  output logic             strobe_ext_o
);
  localparam logic [CNT_W-1:0] ONE = {{(CNT_W-1){1'b0}}, 1'b1};

  logic [CNT_W-1:0] cnt_q;
  logic strobe_q, start_q, ext_q, armed_q, gap_q;

  logic [CNT_W-1:0] dur_eff, gap_eff;
  logic int_trig, any_trig;

  assign dur_eff  = (dur_cfg == '0) ? ONE : dur_cfg;
  assign gap_eff  = (gap_cfg == '0) ? ONE : gap_cfg;
  assign int_trig = gap_q & seq_en & (cnt_q == ONE);
  assign any_trig = trig_i | int_trig;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q    <= '0;
      strobe_q <= 1'b0;
      start_q  <= 1'b0;
      ext_q    <= 1'b0;
      armed_q  <= 1'b0;
      gap_q    <= 1'b0;
    end else begin
      start_q <= any_trig & ~strobe_q;
      if (!seq_en)     armed_q <= 1'b0;
      else if (trig_i) armed_q <= 1'b1;
      if (any_trig) begin
        cnt_q    <= dur_eff;
        strobe_q <= 1'b1;
        gap_q    <= 1'b0;
        ext_q    <= strobe_q;
      end else if (strobe_q) begin
        if (cnt_q == ONE) begin
          strobe_q <= 1'b0;
          gap_q    <= armed_q & seq_en;
          cnt_q    <= gap_eff;
        end else begin
          cnt_q <= cnt_q - ONE;
        end
      end else if (gap_q) begin
        if (!seq_en) gap_q <= 1'b0;
        else         cnt_q <= cnt_q - ONE;
      end
    end
  end

  assign strobe_o       = strobe_q;
  assign strobe_start_o = start_q;
  assign strobe_ext_o   = ext_q;

  p_start_on_rise_r4: assert property (@(posedge clk) disable iff (!rst_n)
    start_q == $rose(strobe_q));
  p_trig_opens_r2: assert property (@(posedge clk) disable iff (!rst_n)
    trig_i |=> strobe_q);
  p_ext_set_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (trig_i && strobe_q) |=> ext_q);
  p_ext_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
    start_q |-> !ext_q);
  p_no_start_disabled_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!seq_en && !trig_i) |=> !start_q);
  p_extend_holds_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe_q && trig_i) |=> (strobe_q && !start_q));
endmodule

// File: tb/sim_strobe_sequencer.sv
module sim_strobe_sequencer;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic trig = 1'b0;
  logic en = 1'b0;
  logic [7:0] dur = 8'd3;
  logic [7:0] gap = 8'd2;
  logic strobe, start, ext;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  bit cmp_on = 1'b0;

  bit m_str, m_start, m_ext, m_arm, m_seq;
  int m_hi, m_lo;

  always #4 clk = ~clk;

  strobe_sequencer #(.CNT_W(8)) u0 (
    .clk(clk), .rst_n(rst_n), .trig_i(trig), .seq_en(en),
    .dur_cfg(dur), .gap_cfg(gap),
    .strobe_o(strobe), .strobe_start_o(start), .strobe_ext_o(ext)
  );

  task automatic chk(input int act, input int exp, input string tag);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic int at_least_one(input int v);
    return (v == 0) ? 1 : v;
  endfunction

  task automatic model_step();
    bit itrig, fire, arm_n;
    itrig = !m_str && m_seq && en && (m_lo == 1);
    fire = trig || itrig;
    arm_n = en ? (m_arm || trig) : 1'b0;
    m_start = fire && !m_str;
    if (fire) begin
      m_ext = m_str;
      m_str = 1'b1;
      m_hi = at_least_one(int'(dur));
      m_seq = 1'b0;
    end else if (m_str) begin
      m_hi--;
      if (m_hi == 0) begin
        m_str = 1'b0;
        m_seq = m_arm && en;
        m_lo = at_least_one(int'(gap));
      end
    end else if (m_seq) begin
      if (!en) m_seq = 1'b0;
      else m_lo--;
    end
    m_arm = arm_n;
  endtask

  task automatic cyc();
    @(posedge clk);
    model_step();
    @(negedge clk);
    trig = 1'b0;
    if (cmp_on) begin
      chk(int'(strobe), int'(m_str), "R2,R5,R8,R11 strobe");
      chk(int'(start), int'(m_start), "R4 start");
      chk(int'(ext), int'(m_ext), "R6 ext");
    end
  endtask

  task automatic measure(output int n);
    n = 0;
    do begin
      cyc();
      n++;
    end while (!start && n < 100);
  endtask

  task automatic count_starts(input int len, output int s);
    s = 0;
    for (int i = 0; i < len; i++) begin
      cyc();
      if (start) s++;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int n, s;
    void'($urandom(32'd12345));
    m_str = 0; m_start = 0; m_ext = 0; m_arm = 0; m_seq = 0; m_hi = 0; m_lo = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    chk(int'(strobe), 0, "R1 strobe");
    chk(int'(start), 0, "R1 start");
    chk(int'(ext), 0, "R1 ext");

    trig = 1'b1; cyc();
    chk(int'(strobe), 1, "R2 open");
    chk(int'(start), 1, "R4 pulse");
    cyc();
    chk(int'(start), 0, "R4 single");
    chk(int'(strobe), 1, "R2 hold");
    cyc();
    chk(int'(strobe), 1, "R2 hold");
    cyc();
    chk(int'(strobe), 0, "R2 close");
    cyc();

    dur = 8'd0;
    trig = 1'b1; cyc();
    chk(int'(strobe), 1, "R3 open");
    cyc();
    chk(int'(strobe), 0, "R3 one cycle");
    cyc();

    dur = 8'd4;
    trig = 1'b1; cyc();
    cyc();
    trig = 1'b1; cyc();
    chk(int'(strobe), 1, "R5 extended");
    chk(int'(ext), 1, "R6 set");
    cyc(); cyc(); cyc();
    chk(int'(strobe), 1, "R5 full duration");
    cyc();
    chk(int'(strobe), 0, "R5 close");
    chk(int'(ext), 1, "R6 hold");
    trig = 1'b1; cyc();
    chk(int'(ext), 0, "R6 clear");
    repeat (6) cyc();

    en = 1'b1; dur = 8'd2; gap = 8'd3;
    count_starts(20, s);
    chk(s, 0, "R7 enable alone");

    trig = 1'b1; cyc();
    measure(n);
    chk(n, 5, "R8 period");
    measure(n);
    chk(n, 5, "R8 period repeat");

    gap = 8'd0;
    measure(n);
    measure(n);
    chk(n, 3, "R9 zero gap");

    gap = 8'd4;
    measure(n);
    measure(n);
    chk(n, 6, "R8 period 6");
    cyc(); cyc();
    chk(int'(strobe), 0, "R11 in gap");
    trig = 1'b1; cyc();
    chk(int'(strobe), 1, "R11 retime open");
    chk(int'(start), 1, "R11 retime start");
    measure(n);
    chk(n, 6, "R11 period from retime");

    en = 1'b0;
    count_starts(30, s);
    chk(s, 0, "R10 stopped");
    chk(int'(strobe), 0, "R10 closed");
    en = 1'b1;
    count_starts(30, s);
    chk(s, 0, "R12 disarmed");

    cmp_on = 1'b1;
    for (int i = 0; i < 4000; i++) begin
      if ($urandom % 11 == 0) trig = 1'b1;
      if ($urandom % 97 == 0) en = ~en;
      if ($urandom % 53 == 0) dur = 8'($urandom % 6);
      if ($urandom % 59 == 0) gap = 8'($urandom % 6);
      cyc();
    end

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule